// File: doc/BRIEF.md
# Wrap-Aware Virtual-Channel Level Router

This block computes the route and the virtual-channel level for a head flit at one router of a unidirectional k-ary n-cube with wrap-around links. It receives the coordinates of the current node, the coordinates of the destination and the level on which the flit arrived. It returns the dimension to travel in next, the level to use on that outgoing link, and whether the flit should leave the network at this node instead.

Routing is dimension-ordered. The lowest-numbered dimension whose coordinate still differs from the destination is corrected first. Every hop moves one step upward in that dimension, modulo the radix. A hop that leaves coordinate K-1 for coordinate 0 crosses a wrap-around link, and the flit then moves up one level. Levels therefore only rise along a route. A packet starts at level 0 and makes at most one wrap per dimension, so it never needs more than N+1 levels, and the channel dependence graph stays acyclic.

The decision is combinational. A parameter selects whether one register stage is placed at the output. Coordinates are packed with dimension d in bits [d*CW +: CW], where CW = ceil(log2 K).

Top module: `torus_vc_route`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid, out_eject, out_err, out_dim and out_lvl are all 0.
- R2: For a flit that is not at its destination, out_dim is the lowest dimension index d where the cur_coord field [d*CW +: CW] differs from the dst_coord field.
- R3: When the current coordinate in the selected dimension is below K-1, the hop does not wrap and out_lvl equals in_lvl.
- R4: When the current coordinate in the selected dimension equals K-1 and in_lvl is below N, the hop wraps and out_lvl equals in_lvl + 1.
- R5: When every coordinate field matches the destination, out_eject is 1 and out_dim, out_lvl and out_err are 0, whatever the value of in_lvl.
- R6: When a wrap is needed and in_lvl is N or higher, out_err is 1, out_eject is 0, out_lvl equals in_lvl, and out_dim still names the selected dimension.
- R7: With REG_OUT=1, every output reflects the inputs sampled at the previous rising clock edge, and out_valid follows in_valid. A cycle with in_valid low gives all outputs 0 on the next cycle.
- R8: Take a 4-ary 2-cube, any source and any destination, a start at level 0, and each hop applied as (c+1) mod K in out_dim. Such a walk reaches ejection within N*(K-1) hops. Its level never decreases, never exceeds N, and out_err never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Head flit present |
| cur_coord | input | N*CW | Coordinates of this node, dimension d at [d*CW +: CW] |
| dst_coord | input | N*CW | Destination coordinates, same packing |
| in_lvl | input | LW | Arrival virtual-channel level, LW = ceil(log2(N+1)) |
| out_valid | output | 1 | Result valid |
| out_eject | output | 1 | Deliver to the local port |
| out_err | output | 1 | Level budget exhausted at a needed wrap |
| out_dim | output | DW | Outgoing dimension, DW = max(1, ceil(log2 N)) |
| out_lvl | output | LW | Outgoing virtual-channel level |

## Verification
Dimension selection and the wrap-driven level raise are resolved in the same cycle. A fault only arises when a wrap falls together with an arrival level that is already at the top. The bench provokes this overlap directly: it drives a node at coordinate K-1 in the lowest differing dimension while in_lvl is 0, 1 and N. It then checks that the level rises only in the first two cases and that the third yields an error with the dimension still reported. A behavioural model compares every output on every clock, and an exhaustive hop-by-hop walk of all 256 source/destination pairs in a 4-ary 2-cube shows that the two functions together keep the level monotonic and bounded.

// File: rtl/torus_rc_pkg.sv
package torus_rc_pkg;

    // Outcome class of one routing decision
    typedef enum logic [1:0] {
        RK_IDLE  = 2'd0,
        RK_HOP   = 2'd1,
        RK_EJECT = 2'd2,
        RK_FAULT = 2'd3
    } route_kind_e;

    // Bits needed to index n distinct values, at least one
    function automatic int width_of(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/torus_dim_scan.sv
module torus_dim_scan #(
    parameter int K  = 4,
    parameter int N  = 2,
    parameter int CW = 2,
    parameter int DW = 1
) (
    input  logic [N*CW-1:0] cur,
    input  logic [N*CW-1:0] dst,
    output logic            at_dest,
    output logic [DW-1:0]   sel_dim,
    output logic [CW-1:0]   sel_coord
);

    logic [N-1:0] differs;

    // One comparator per dimension
    for (genvar d = 0; d < N; d++) begin : g_cmp
        assign differs[d] = cur[d*CW +: CW] != dst[d*CW +: CW];
    end

    assign at_dest = ~|differs;

    // Lowest differing dimension wins: dimension order
    always_comb begin
        logic found;
        found   = 1'b0;
        sel_dim = '0;
        for (int d = 0; d < N; d++) begin
            if (!found && differs[d]) begin
                found   = 1'b1;
                sel_dim = DW'(d);
            end
        end
    end

    // Coordinate of this node in the chosen dimension
    always_comb begin
        sel_coord = '0;
        for (int d = 0; d < N; d++) begin
            if (sel_dim == DW'(d)) sel_coord = cur[d*CW +: CW];
        end
    end

endmodule

// File: rtl/torus_lvl_calc.sv
module torus_lvl_calc
    import torus_rc_pkg::*;
#(
    parameter int K  = 4,
    parameter int N  = 2,
    parameter int CW = 2,
    parameter int LW = 2
) (
    input  logic [CW-1:0] sel_coord,
    input  logic          at_dest,
    input  logic [LW-1:0] in_lvl,
    output route_kind_e   kind,
    output logic [LW-1:0] lvl_out
);

    logic wraps;
    logic spent;

    assign wraps = sel_coord == CW'(K - 1);
    assign spent = in_lvl >= LW'(N);

    always_comb begin
        if (at_dest) begin
            kind    = RK_EJECT;
            lvl_out = '0;
        end else if (wraps && spent) begin
            kind    = RK_FAULT;
            lvl_out = in_lvl;
        end else begin
            kind    = RK_HOP;
            lvl_out = in_lvl + LW'(wraps);
        end
    end

endmodule

// File: rtl/torus_out_stage.sv
module torus_out_stage
    import torus_rc_pkg::*;
#(
    parameter int DW      = 1,
    parameter int LW      = 2,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  route_kind_e   kind,
    input  logic [DW-1:0] dim,
    input  logic [LW-1:0] lvl,
    output logic          out_valid,
    output logic          out_eject,
    output logic          out_err,
    output logic [DW-1:0] out_dim,
    output logic [LW-1:0] out_lvl
);

    route_kind_e   k_eff;
    logic          v_n, ej_n, er_n;
    logic [DW-1:0] dim_n;
    logic [LW-1:0] lvl_n;

    always_comb begin
        k_eff = in_valid ? kind : RK_IDLE;
        v_n   = in_valid;
        ej_n  = k_eff == RK_EJECT;
        er_n  = k_eff == RK_FAULT;
        dim_n = (k_eff == RK_HOP || k_eff == RK_FAULT) ? dim : '0;
        lvl_n = (k_eff == RK_HOP || k_eff == RK_FAULT) ? lvl : '0;
    end

    if (REG_OUT) begin : g_reg
        logic armed_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                out_eject <= 1'b0;
                out_err   <= 1'b0;
                out_dim   <= '0;
                out_lvl   <= '0;
                armed_q   <= 1'b0;
            end else begin
                out_valid <= v_n;
                out_eject <= ej_n;
                out_err   <= er_n;
                out_dim   <= dim_n;
                out_lvl   <= lvl_n;
                armed_q   <= 1'b1;
            end
        end

        // R7
        valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
            armed_q |-> (out_valid == $past(in_valid)));

        // R1
        reset_clear_chk: assert property (@(posedge clk)
            $past(rst) |-> (!out_valid && !out_eject && !out_err));
    end else begin : g_comb
        always_comb begin
            out_valid = v_n;
            out_eject = ej_n;
            out_err   = er_n;
            out_dim   = dim_n;
            out_lvl   = lvl_n;
        end
    end

endmodule

// File: rtl/torus_vc_route.sv
module torus_vc_route
    import torus_rc_pkg::*;
#(
    parameter int  K       = 4,
    parameter int  N       = 2,
    parameter bit  REG_OUT = 1'b1,
    localparam int CW      = width_of(K),
    localparam int LW      = width_of(N + 1),
    localparam int DW      = width_of(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [N*CW-1:0] cur_coord,
    input  logic [N*CW-1:0] dst_coord,
    input  logic [LW-1:0]   in_lvl,
    output logic            out_valid,
    output logic            out_eject,
    output logic            out_err,
    output logic [DW-1:0]   out_dim,
    output logic [LW-1:0]   out_lvl
);

    logic          at_dest;
    logic [DW-1:0] sel_dim;
    logic [CW-1:0] sel_coord;
    route_kind_e   kind;
    logic [LW-1:0] next_lvl;

    torus_dim_scan #(.K(K), .N(N), .CW(CW), .DW(DW)) u_scan (
        .cur       (cur_coord),
        .dst       (dst_coord),
        .at_dest   (at_dest),
        .sel_dim   (sel_dim),
        .sel_coord (sel_coord)
    );

    torus_lvl_calc #(.K(K), .N(N), .CW(CW), .LW(LW)) u_lvl (
        .sel_coord (sel_coord),
        .at_dest   (at_dest),
        .in_lvl    (in_lvl),
        .kind      (kind),
        .lvl_out   (next_lvl)
    );

    torus_out_stage #(.DW(DW), .LW(LW), .REG_OUT(REG_OUT)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .kind      (kind),
        .dim       (sel_dim),
        .lvl       (next_lvl),
        .out_valid (out_valid),
        .out_eject (out_eject),
        .out_err   (out_err),
        .out_dim   (out_dim),
        .out_lvl   (out_lvl)
    );

    // R3 R4: a hop never lowers the level and raises it by at most one
    lvl_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == RK_HOP) |->
            (next_lvl >= in_lvl && next_lvl - in_lvl <= LW'(1)));

    // R5
    eject_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && at_dest) |-> (kind == RK_EJECT && next_lvl == '0));

    // R6
    fault_budget_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == RK_FAULT) |-> (in_lvl >= LW'(N) && !at_dest));

    // R2: the chosen dimension is never one that already matches
    dim_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !at_dest) |->
            (cur_coord[sel_dim*CW +: CW] != dst_coord[sel_dim*CW +: CW]));

endmodule

// File: tb/torus_vc_route_test.sv
module torus_vc_route_test;

    localparam int CLK_PERIOD = 10;
    localparam int K  = 4;
    localparam int N  = 2;
    localparam int CW = 2;
    localparam int LW = 2;
    localparam int DW = 1;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic [N*CW-1:0] cur_coord;
    logic [N*CW-1:0] dst_coord;
    logic [LW-1:0]   in_lvl;
    logic            out_valid, out_eject, out_err;
    logic [DW-1:0]   out_dim;
    logic [LW-1:0]   out_lvl;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    torus_vc_route #(.K(K), .N(N), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .cur_coord(cur_coord), .dst_coord(dst_coord), .in_lvl(in_lvl),
        .out_valid(out_valid), .out_eject(out_eject), .out_err(out_err),
        .out_dim(out_dim), .out_lvl(out_lvl)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Behavioural model of one routing decision
    function automatic void model(input logic [N*CW-1:0] c, input logic [N*CW-1:0] d,
                                  input int lvl, input bit v,
                                  output int vo, output int ej, output int er,
                                  output int dim, output int nl, output bit wr);
        int cc;
        vo = v; ej = 0; er = 0; dim = 0; nl = 0; wr = 0;
        if (!v) return;
        ej = 1;
        for (int i = N - 1; i >= 0; i--) begin
            if (c[i*CW +: CW] != d[i*CW +: CW]) begin
                ej = 0;
                dim = i;
            end
        end
        if (ej) return;
        cc = int'(c[dim*CW +: CW]);
        wr = (cc == K - 1);
        if (wr && lvl >= N) begin
            er = 1;
            nl = lvl;
        end else begin
            nl = lvl + (wr ? 1 : 0);
        end
    endfunction

    // Drive one flit at a falling edge, compare one clock later
    task automatic step(input logic [N*CW-1:0] c, input logic [N*CW-1:0] d,
                        input int lvl, input bit v);
        int vo, ej, er, dim, nl;
        bit wr;
        @(negedge clk);
        cur_coord = c;
        dst_coord = d;
        in_lvl    = LW'(lvl);
        in_valid  = v;
        model(c, d, lvl, v, vo, ej, er, dim, nl, wr);
        @(negedge clk);
        check("R7 out_valid", int'(out_valid), vo);
        check("R5 out_eject", int'(out_eject), ej);
        check("R6 out_err", int'(out_err), er);
        check("R2 out_dim", int'(out_dim), dim);
        if (wr) check("R4 out_lvl", int'(out_lvl), nl);
        else    check("R3 out_lvl", int'(out_lvl), nl);
    endtask

    function automatic logic [N*CW-1:0] xy(input int x, input int y);
        return {CW'(y), CW'(x)};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog R8 actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b1;
        cur_coord = xy(3, 1); dst_coord = xy(0, 2); in_lvl = 2'd1;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_eject", int'(out_eject), 0);
        check("R1 out_err", int'(out_err), 0);
        check("R1 out_lvl", int'(out_lvl), 0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check("R1 post out_valid", int'(out_valid), 0);

        // R7: invalid cycle yields all zeros
        step(xy(3, 3), xy(1, 0), 1, 1'b0);
        // R2 R3: x first, no wrap
        step(xy(0, 0), xy(1, 2), 0, 1'b1);
        // R2: x matches, y chosen
        step(xy(2, 0), xy(2, 3), 1, 1'b1);
        // R4: wrap in x raises level
        step(xy(3, 0), xy(1, 0), 0, 1'b1);
        step(xy(3, 2), xy(2, 2), 1, 1'b1);
        // R4: wrap in y
        step(xy(1, 3), xy(1, 0), 1, 1'b1);
        // R5: destination reached, level ignored
        step(xy(2, 1), xy(2, 1), 2, 1'b1);
        step(xy(0, 0), xy(0, 0), 3, 1'b1);
        // R6: wrap needed with level already at N
        step(xy(3, 1), xy(0, 1), 2, 1'b1);
        step(xy(1, 3), xy(1, 2), 2, 1'b1);
        // R3: level at N without a wrap is passed on
        step(xy(1, 1), xy(2, 1), 2, 1'b1);

        // R8: exhaustive hop-by-hop walk
        for (int s = 0; s < K*K; s++) begin
            for (int t = 0; t < K*K; t++) begin
                logic [N*CW-1:0] c, d;
                int lvl, hops, prev;
                bit done;
                c = (N*CW)'(s); d = (N*CW)'(t);
                lvl = 0; hops = 0; done = 0;
                while (!done && hops <= N*(K-1)) begin
                    step(c, d, lvl, 1'b1);
                    if (out_eject) begin
                        done = 1;
                    end else begin
                        prev = lvl;
                        if (out_err || int'(out_lvl) < prev || int'(out_lvl) > N)
                            check("R8 level", int'(out_lvl), prev);
                        lvl = int'(out_lvl);
                        c[int'(out_dim)*CW +: CW] = CW'((int'(c[int'(out_dim)*CW +: CW]) + 1) % K);
                        hops++;
                    end
                end
                check("R8 terminate", int'(done), 1);
                check("R8 arrival", int'(c), int'(d));
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule